// File: doc/BRIEF.md
# Fused Read-Modify-Write Operation ALU

This block computes the results of opcodes that fuse two operations into one pass. A memory operand is shifted, rotated, incremented or decremented and written back, and the modified value then feeds a logic, compare or add step against the accumulator. Its other work is a set of immediate-operand operations that AND the operand into the accumulator and then shift, rotate or copy a bit into carry. One of these ORs in a constant that is set at build time. Only binary arithmetic is supported.

The surrounding sequencer presents an opcode, the accumulator, the X register, the fetched memory operand and the carry flag, and raises `in_valid` for one cycle. One cycle later the block raises `out_valid` for one cycle. With it come a new accumulator, a new memory byte, and a new N/V/Z/C flag set. Each of these has its own write enable, so the sequencer commits only what the opcode changes. An opcode outside the supported set raises `unsupported` and asserts no write enable.

Top module: `fused_op_alu`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid`, `acc_we`, `mem_we`, `unsupported` and all `flag_en` bits are 0.
- R2: A request sampled with `in_valid` high yields `out_valid` high on the next cycle only. The signals `acc_we`, `mem_we`, `flag_en` and `unsupported` are 0 whenever `out_valid` is 0.
- R3: The shift-then-logic and rotate-then-add families behave as follows. The family is selected by opcode bits [7:5] when bits [1:0] are 11 and bits [4:2] are not 010:
  - 000: memory shifts left, and A becomes A OR the new memory value.
  - 001: memory rotates left through carry, and A becomes A AND the new memory value.
  - 010: memory shifts right, and A becomes A EOR the new memory value.
  - 011: memory rotates right through carry, and A becomes A + new memory value + carry, where the carry is old memory bit 0.
  - C takes the bit shifted out of memory for the first three families. The rotate-then-add family sets C and V from the addition.
  - N and Z follow the new A.
- R4: Family 110 of the same decode decrements memory and writes it back. It then compares A with the new value: C=1 when A is greater than or equal to it, and Z and N come from the difference. A is not written.
- R5: Family 111 increments memory and writes it back. It then sets A = A − M − (1 − C) and updates N, V, Z and C.
- R6: Family 100, with bits [4:0] equal to 03, 07, 0F or 17, stores A AND X to memory. It enables no flag and does not write A.
- R7: Opcode 0x4B sets t = A AND operand and A = t shifted right by one. C = t bit 0, N = 0, and Z is updated.
- R8: Opcodes 0x0B and 0x2B set A = A AND operand, with C = bit 7 of the new A, and update N and Z.
- R9: Opcode 0x6B sets t = A AND operand and rotates t right through the old carry into A. C = A bit 6 and V = A bit 6 XOR A bit 5, and N and Z are updated.
- R10: Opcode 0x8B sets A = (A OR ANE_MAGIC) AND X AND operand and updates N and Z only. ANE_MAGIC defaults to 0xEE, and 0xEF is the alternative.
- R11: Opcode 0xEB sets A = A − operand − (1 − C) and updates N, V, Z and C.
- R12: Any other opcode, including 0x02, 0xA7, 0xAB, 0xCB and 0xEA, sets `unsupported` and leaves every write enable 0.
- R13: Flag vectors use bit 3 = N, bit 2 = V, bit 1 = Z and bit 0 = C. A flag output bit is meaningful only where its `flag_en` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Operation encoding |
| acc_in | input | W | Accumulator |
| xr_in | input | W | X register |
| mem_in | input | W | Memory or immediate operand |
| carry_in | input | 1 | Carry flag |
| out_valid | output | 1 | Result strobe, one cycle |
| acc_out | output | W | New accumulator |
| acc_we | output | 1 | Accumulator write enable |
| mem_out | output | W | New memory byte |
| mem_we | output | 1 | Memory write enable |
| flags_out | output | 4 | New N,V,Z,C values |
| flag_en | output | 4 | Per-flag update enables |
| unsupported | output | 1 | Opcode not in the supported set |

## Verification
Every one of the 256 opcodes is driven with four operand patterns:
- all zeros with carry clear, which separates flag behaviour on zero results;
- all ones with carry set, which exposes wrap-around in the increment, decrement and borrow paths;
- sign-bit and low-bit boundary values, which expose shift-out and overflow mistakes;
- alternating bit patterns, which catch swapped or misordered bits in rotations and logic steps.

Directed cases then cover the memory wrap at 0x00 and 0xFF, equality in the compare, the bit 6 and bit 5 carry and overflow rule of the rotate-immediate, the build-time constant, and each addressing-mode encoding of one family. Back-to-back requests followed by idle cycles show that exactly one result strobe appears per request.

// File: rtl/fused_alu_pkg.sv
// Shared types for the fused-operation ALU.
// Assumes: flag vectors are ordered N,V,Z,C from the top bit down.
package fused_alu_pkg;
    localparam int NFLAG  = 4;
    localparam int FLAG_N = 3;
    localparam int FLAG_V = 2;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;

    typedef enum logic [3:0] {
        K_NONE, K_SHL_OR, K_ROL_AND, K_SHR_EOR, K_ROR_ADD,
        K_STORE_AX, K_DEC_CMP, K_INC_SUB,
        K_AND_SHR, K_AND_B7C, K_AND_ROR, K_MAGIC_AND, K_SUB_IMM
    } op_kind_e;
endpackage

// File: rtl/fused_alu_decode.sv
// Maps an 8-bit opcode to an operation kind.
// Assumes: memory families are chosen by bits [7:5] when bits [1:0]=11 and
// bits [4:2]!=010; immediate ops share bits [4:0]=01011.
module fused_alu_decode
    import fused_alu_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind
);
    logic mem_mode;
    logic imm_mode;
    logic store_mode;

    // Classify the addressing-mode bits.
    always_comb begin
        mem_mode   = (opcode[1:0] == 2'b11) && (opcode[4:2] != 3'b010);
        imm_mode   = (opcode[4:0] == 5'b01011);
        store_mode = (opcode[4:2] == 3'b000) || (opcode[4:2] == 3'b001) ||
                     (opcode[4:2] == 3'b011) || (opcode[4:2] == 3'b101);
    end

    // Select the operation kind from the family bits.
    always_comb begin
        kind = K_NONE;
        if (mem_mode) begin
            case (opcode[7:5])
                3'd0:    kind = K_SHL_OR;
                3'd1:    kind = K_ROL_AND;
                3'd2:    kind = K_SHR_EOR;
                3'd3:    kind = K_ROR_ADD;
                3'd4:    kind = store_mode ? K_STORE_AX : K_NONE;
                3'd6:    kind = K_DEC_CMP;
                3'd7:    kind = K_INC_SUB;
                default: kind = K_NONE;
            endcase
        end else if (imm_mode) begin
            case (opcode[7:5])
                3'd0, 3'd1: kind = K_AND_B7C;
                3'd2:       kind = K_AND_SHR;
                3'd3:       kind = K_AND_ROR;
                3'd4:       kind = K_MAGIC_AND;
                3'd7:       kind = K_SUB_IMM;
                default:    kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fused_alu_adder.sv
// W-bit adder with carry in, carry out and signed overflow.
// Assumes: subtraction is presented as p + ~q + cin by the caller.
module fused_alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    // Add with one spare bit for the carry, then derive overflow from signs.
    always_comb begin
        wide = {1'b0, p} + {1'b0, q} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (p[W-1] == q[W-1]) && (sum[W-1] != p[W-1]);
    end
endmodule

// File: rtl/fused_alu_core.sv
// Combinational datapath: modifies the memory operand, runs the second
// operation and builds result values, write enables and flag enables.
// Assumes: binary arithmetic only; W is at least 3.
module fused_alu_core
    import fused_alu_pkg::*;
#(
    parameter int           W         = 8,
    parameter logic [W-1:0] ANE_MAGIC = 8'hEE
) (
    input  op_kind_e         kind,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     x,
    input  logic [W-1:0]     m,
    input  logic             c,
    output logic [W-1:0]     acc_n,
    output logic             acc_we,
    output logic [W-1:0]     mem_n,
    output logic             mem_we,
    output logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] flag_en,
    output logic             unsup
);
    localparam logic [W-1:0]     ONE   = W'(1);
    localparam logic [NFLAG-1:0] EN_NZ = NFLAG'((1 << FLAG_N) | (1 << FLAG_Z));
    localparam logic [NFLAG-1:0] EN_NZC = EN_NZ | NFLAG'(1 << FLAG_C);
    localparam logic [NFLAG-1:0] EN_ALL = EN_NZC | NFLAG'(1 << FLAG_V);

    logic [W-1:0] mod_m;
    logic [W-1:0] add_q;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] masked;
    logic [W-1:0] res;
    logic [W-1:0] nz_src;
    logic         cf;
    logic         vf;

    // First operation: modify the memory operand and prepare the adder.
    always_comb begin
        mod_m   = m;
        add_q   = m;
        add_cin = c;
        case (kind)
            K_SHL_OR:  mod_m = {m[W-2:0], 1'b0};
            K_ROL_AND: mod_m = {m[W-2:0], c};
            K_SHR_EOR: mod_m = {1'b0, m[W-1:1]};
            K_ROR_ADD: begin
                mod_m   = {c, m[W-1:1]};
                add_q   = {c, m[W-1:1]};
                add_cin = m[0];
            end
            K_DEC_CMP: begin
                mod_m   = m - ONE;
                add_q   = ~(m - ONE);
                add_cin = 1'b1;
            end
            K_INC_SUB: begin
                mod_m = m + ONE;
                add_q = ~(m + ONE);
            end
            K_SUB_IMM: add_q = ~m;
            default:   ;
        endcase
    end

    fused_alu_adder #(.W(W)) u_add (
        .p(a), .q(add_q), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    // Second operation: result, write enables and flags.
    always_comb begin
        masked  = a & m;
        res     = a;
        mem_n   = mod_m;
        acc_we  = 1'b0;
        mem_we  = 1'b0;
        flag_en = '0;
        unsup   = 1'b0;
        cf      = c;
        vf      = 1'b0;
        case (kind)
            K_SHL_OR: begin
                res = a | mod_m; acc_we = 1'b1; mem_we = 1'b1;
                cf = m[W-1]; flag_en = EN_NZC;
            end
            K_ROL_AND: begin
                res = a & mod_m; acc_we = 1'b1; mem_we = 1'b1;
                cf = m[W-1]; flag_en = EN_NZC;
            end
            K_SHR_EOR: begin
                res = a ^ mod_m; acc_we = 1'b1; mem_we = 1'b1;
                cf = m[0]; flag_en = EN_NZC;
            end
            K_ROR_ADD, K_INC_SUB: begin
                res = add_sum; acc_we = 1'b1; mem_we = 1'b1;
                cf = add_cout; vf = add_ovf; flag_en = EN_ALL;
            end
            K_STORE_AX: begin
                mem_n = a & x; mem_we = 1'b1;
            end
            K_DEC_CMP: begin
                mem_we = 1'b1; cf = add_cout; flag_en = EN_NZC;
            end
            K_AND_SHR: begin
                res = {1'b0, masked[W-1:1]}; acc_we = 1'b1;
                cf = masked[0]; flag_en = EN_NZC;
            end
            K_AND_B7C: begin
                res = masked; acc_we = 1'b1;
                cf = masked[W-1]; flag_en = EN_NZC;
            end
            K_AND_ROR: begin
                res = {c, masked[W-1:1]}; acc_we = 1'b1;
                cf = masked[W-1]; vf = masked[W-1] ^ masked[W-2];
                flag_en = EN_ALL;
            end
            K_MAGIC_AND: begin
                res = (a | ANE_MAGIC) & x & m; acc_we = 1'b1;
                flag_en = EN_NZ;
            end
            K_SUB_IMM: begin
                res = add_sum; acc_we = 1'b1;
                cf = add_cout; vf = add_ovf; flag_en = EN_ALL;
            end
            default: unsup = 1'b1;
        endcase
    end

    // N and Z come from the compare difference or from the new accumulator.
    always_comb begin
        nz_src        = (kind == K_DEC_CMP) ? add_sum : res;
        acc_n         = res;
        flags         = '0;
        flags[FLAG_N] = nz_src[W-1];
        flags[FLAG_Z] = (nz_src == '0);
        flags[FLAG_C] = cf;
        flags[FLAG_V] = vf;
    end
endmodule

// File: rtl/fused_op_alu.sv
// Top level: decodes the opcode, runs the fused datapath and registers the
// results behind a one-cycle strobe.
// Assumes: one request per in_valid cycle; strobes are zero when idle.
module fused_op_alu
    import fused_alu_pkg::*;
#(
    parameter int           W         = 8,
    parameter logic [W-1:0] ANE_MAGIC = 8'hEE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [7:0]   opcode,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] xr_in,
    input  logic [W-1:0] mem_in,
    input  logic         carry_in,
    output logic         out_valid,
    output logic [W-1:0] acc_out,
    output logic         acc_we,
    output logic [W-1:0] mem_out,
    output logic         mem_we,
    output logic [3:0]   flags_out,
    output logic [3:0]   flag_en,
    output logic         unsupported
);
    op_kind_e         kind;
    logic [W-1:0]     c_acc;
    logic [W-1:0]     c_mem;
    logic             c_acc_we;
    logic             c_mem_we;
    logic [NFLAG-1:0] c_flags;
    logic [NFLAG-1:0] c_fen;
    logic             c_unsup;

    fused_alu_decode u_dec (.opcode(opcode), .kind(kind));

    fused_alu_core #(.W(W), .ANE_MAGIC(ANE_MAGIC)) u_core (
        .kind(kind), .a(acc_in), .x(xr_in), .m(mem_in), .c(carry_in),
        .acc_n(c_acc), .acc_we(c_acc_we), .mem_n(c_mem), .mem_we(c_mem_we),
        .flags(c_flags), .flag_en(c_fen), .unsup(c_unsup)
    );

    // Result register: capture on a request, clear strobes when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            acc_out     <= '0;
            mem_out     <= '0;
            flags_out   <= '0;
            acc_we      <= 1'b0;
            mem_we      <= 1'b0;
            flag_en     <= '0;
            unsupported <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_out     <= c_acc;
                mem_out     <= c_mem;
                flags_out   <= c_flags;
                acc_we      <= c_acc_we;
                mem_we      <= c_mem_we;
                flag_en     <= c_fen;
                unsupported <= c_unsup;
            end else begin
                acc_we      <= 1'b0;
                mem_we      <= 1'b0;
                flag_en     <= '0;
                unsupported <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fused_op_alu_chk.sv
// Property checker for fused_op_alu, attached by bind.
// Assumes: synchronous active-low reset; opcodes as listed in the brief.
module fused_op_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [7:0]   opcode,
    input logic [W-1:0] acc_in,
    input logic [W-1:0] xr_in,
    input logic [W-1:0] mem_in,
    input logic         out_valid,
    input logic         acc_we,
    input logic [W-1:0] mem_out,
    input logic         mem_we,
    input logic [3:0]   flags_out,
    input logic [3:0]   flag_en,
    input logic         unsupported
);
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_enables_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we || mem_we || unsupported || (flag_en != 4'd0)) |-> out_valid);

    a_r12_unsup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!acc_we && !mem_we && flag_en == 4'd0));

    a_r6_store_ax: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 8'h83 || opcode == 8'h87 ||
                      opcode == 8'h8F || opcode == 8'h97))
        |=> (mem_we && !acc_we && flag_en == 4'd0 &&
             mem_out == ($past(acc_in) & $past(xr_in))));

    a_r4_dec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'hC7)
        |=> (mem_we && mem_out == W'($past(mem_in) - W'(1))));

    a_r7_n_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h4B) |=> (flag_en[3] && !flags_out[3]));
endmodule

bind fused_op_alu fused_op_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .acc_in(acc_in), .xr_in(xr_in), .mem_in(mem_in),
    .out_valid(out_valid), .acc_we(acc_we), .mem_out(mem_out),
    .mem_we(mem_we), .flags_out(flags_out), .flag_en(flag_en),
    .unsupported(unsupported)
);

// File: tb/fused_op_alu_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes model results, the monitor pops and
// compares them against each result strobe.
module fused_op_alu_tb;
    localparam logic [7:0] MAGIC = 8'hEF;

    typedef struct packed {
        logic [7:0] acc;
        logic       acc_we;
        logic [7:0] mem;
        logic       mem_we;
        logic [3:0] fl;
        logic [3:0] fen;
        logic       uns;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] acc_in = 8'h00, xr_in = 8'h00, mem_in = 8'h00;
    logic       carry_in = 1'b0;
    logic       out_valid, acc_we, mem_we, unsupported;
    logic [7:0] acc_out, mem_out;
    logic [3:0] flags_out, flag_en;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t q[$];
    string qreq[$];

    always #2 clk = ~clk;

    fused_op_alu #(.W(8), .ANE_MAGIC(MAGIC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .acc_in(acc_in), .xr_in(xr_in), .mem_in(mem_in), .carry_in(carry_in),
        .out_valid(out_valid), .acc_out(acc_out), .acc_we(acc_we),
        .mem_out(mem_out), .mem_we(mem_we), .flags_out(flags_out),
        .flag_en(flag_en), .unsupported(unsupported)
    );

    // Reference model written from the requirements (flag order N,V,Z,C).
    function automatic exp_t model(input logic [7:0] op, a, x, m, input logic c);
        exp_t e;
        int ai, mi, ci, t, mm, rr, nz;
        bit vb, cb, rmw, st;
        e = '0; ai = int'(a); mi = int'(m); ci = int'(c);
        rr = ai; nz = -1; vb = 0; cb = c;
        rmw = (op[1:0] == 2'b11) && (op[4:2] != 3'd2);
        st  = (op[4:0] == 5'h03) || (op[4:0] == 5'h07) ||
              (op[4:0] == 5'h0F) || (op[4:0] == 5'h17);
        e.uns = 1'b1;
        if (rmw && op[7:5] != 3'd5 && !(op[7:5] == 3'd4 && !st)) begin
            e.uns = 1'b0;
            case (op[7:5])
                3'd0: begin mm = (mi * 2) & 255; cb = m[7]; rr = ai | mm; end
                3'd1: begin mm = ((mi * 2) & 255) | ci; cb = m[7]; rr = ai & mm; end
                3'd2: begin mm = mi / 2; cb = m[0]; rr = ai ^ mm; end
                3'd3: begin
                    mm = ci * 128 + mi / 2;
                    t = ai + mm + (mi % 2);
                    rr = t & 255; cb = (t > 255);
                    vb = ((~(ai ^ mm)) & (ai ^ rr) & 128) != 0;
                end
                3'd4: mm = ai & int'(x);
                3'd6: begin
                    mm = (mi + 255) & 255;
                    cb = (ai >= mm); nz = (ai - mm) & 255;
                end
                default: begin
                    mm = (mi + 1) & 255;
                    t = ai - mm - (1 - ci);
                    rr = t & 255; cb = (t >= 0);
                    vb = ((ai ^ mm) & (ai ^ rr) & 128) != 0;
                end
            endcase
            e.mem = mm[7:0]; e.mem_we = 1'b1;
            e.acc_we = !(op[7:5] == 3'd4 || op[7:5] == 3'd6);
            if (op[7:5] == 3'd4) e.fen = 4'b0000;
            else if (op[7:5] == 3'd3 || op[7:5] == 3'd7) e.fen = 4'b1111;
            else e.fen = 4'b1011;
        end else if (op[4:0] == 5'h0B && op[7:5] != 3'd5 && op[7:5] != 3'd6) begin
            e.uns = 1'b0; e.acc_we = 1'b1; t = ai & mi;
            case (op[7:5])
                3'd0, 3'd1: begin rr = t; cb = (t >= 128); e.fen = 4'b1011; end
                3'd2: begin rr = t / 2; cb = (t % 2) != 0; e.fen = 4'b1011; end
                3'd3: begin
                    rr = ci * 128 + t / 2;
                    cb = ((rr / 64) % 2) != 0;
                    vb = (((rr / 64) ^ (rr / 32)) % 2) != 0;
                    e.fen = 4'b1111;
                end
                3'd4: begin rr = (ai | int'(MAGIC)) & int'(x) & mi; e.fen = 4'b1010; end
                default: begin
                    t = ai - mi - (1 - ci);
                    rr = t & 255; cb = (t >= 0);
                    vb = ((ai ^ mi) & (ai ^ rr) & 128) != 0;
                    e.fen = 4'b1111;
                end
            endcase
        end
        if (nz < 0) nz = rr;
        e.acc = rr[7:0];
        e.fl = {nz >= 128, vb, nz == 0, cb};
        return e;
    endfunction

    function automatic string req_of(input logic [7:0] op);
        if (op[4:0] == 5'h0B) begin
            case (op[7:5])
                3'd0, 3'd1: return "R8";
                3'd2: return "R7";
                3'd3: return "R9";
                3'd4: return "R10";
                3'd7: return "R11";
                default: return "R12";
            endcase
        end
        if (op[1:0] == 2'b11 && op[4:2] != 3'd2) begin
            case (op[7:5])
                3'd4: return "R6";
                3'd5: return "R12";
                3'd6: return "R4";
                3'd7: return "R5";
                default: return "R3";
            endcase
        end
        return "R12";
    endfunction

    // Driver: present one request and push its expected result.
    task automatic send(input logic [7:0] op, a, x, m, input logic c, input string r);
        @(negedge clk);
        opcode = op; acc_in = a; xr_in = x; mem_in = m; carry_in = c;
        in_valid = 1'b1;
        q.push_back(model(op, a, x, m, c));
        qreq.push_back(r);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare every result strobe with the head of the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                n_checks++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2 extra result strobe: actual=1 expected=0");
                end else begin
                    exp_t e;
                    string r;
                    bit bad;
                    e = q.pop_front();
                    r = qreq.pop_front();
                    bad = (unsupported != e.uns) || (acc_we != e.acc_we) ||
                          (mem_we != e.mem_we) || (flag_en != e.fen) ||
                          (e.acc_we && acc_out != e.acc) ||
                          (e.mem_we && mem_out != e.mem) ||
                          (((flags_out ^ e.fl) & e.fen) != 4'd0);
                    if (bad) begin
                        n_fail++;
                        $display("FAIL %s op=%h: actual acc=%h/%b mem=%h/%b fl=%b en=%b u=%b expected acc=%h/%b mem=%h/%b fl=%b en=%b u=%b",
                            r, u_dut.opcode, acc_out, acc_we, mem_out, mem_we, flags_out,
                            flag_en, unsupported, e.acc, e.acc_we, e.mem, e.mem_we,
                            e.fl, e.fen, e.uns);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state, during reset and on the first cycle after it.
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid || acc_we || mem_we || unsupported || flag_en != 4'd0) begin
            n_fail++;
            $display("FAIL R1 reset: actual v=%b a=%b m=%b u=%b en=%b expected all 0",
                     out_valid, acc_we, mem_we, unsupported, flag_en);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid || acc_we || mem_we || unsupported || flag_en != 4'd0) begin
            n_fail++;
            $display("FAIL R1 after reset: actual v=%b expected 0", out_valid);
        end

        // Sweep of all opcodes with four operand patterns (R3..R13).
        for (int op = 0; op < 256; op++) begin
            send(8'(op), 8'h00, 8'h00, 8'h00, 1'b0, req_of(8'(op)));
            send(8'(op), 8'hFF, 8'hFF, 8'hFF, 1'b1, req_of(8'(op)));
            send(8'(op), 8'h80, 8'h7F, 8'h01, 1'b1, req_of(8'(op)));
            send(8'(op), 8'h5A, 8'hC3, 8'hA5, 1'b0, req_of(8'(op)));
        end
        idle(2);

        // R4: memory wrap on decrement, compare equality.
        send(8'hC7, 8'hFF, 8'h00, 8'h00, 1'b0, "R4");
        send(8'hD3, 8'h10, 8'h00, 8'h20, 1'b1, "R4");
        // R5: memory wrap on increment, borrow in.
        send(8'hE7, 8'h00, 8'h00, 8'hFF, 1'b0, "R5");
        send(8'hFB, 8'h80, 8'h00, 8'h00, 1'b1, "R5");
        // R3: rotate-then-add carry from old memory bit 0.
        send(8'h67, 8'hFF, 8'h00, 8'h01, 1'b0, "R3");
        send(8'h27, 8'hFF, 8'h00, 8'h80, 1'b1, "R3");
        // R7/R8/R9: immediate AND forms.
        send(8'h4B, 8'hFF, 8'h00, 8'h81, 1'b0, "R7");
        send(8'h2B, 8'h80, 8'h00, 8'hFF, 1'b0, "R8");
        send(8'h6B, 8'hFF, 8'h00, 8'hFF, 1'b1, "R9");
        send(8'h6B, 8'hC0, 8'h00, 8'hFF, 1'b0, "R9");
        send(8'h6B, 8'h40, 8'h00, 8'hFF, 1'b0, "R9");
        // R10: build-time constant with A=0.
        send(8'h8B, 8'h00, 8'hFF, 8'hFF, 1'b0, "R10");
        // R11: immediate subtract, sign overflow.
        send(8'hEB, 8'h80, 8'h00, 8'h01, 1'b1, "R11");
        send(8'hEB, 8'h00, 8'h00, 8'h01, 1'b1, "R11");
        // R6: store AND of A and X, all encodings.
        send(8'h83, 8'hF0, 8'h3C, 8'h00, 1'b1, "R6");
        send(8'h97, 8'hAA, 8'hFF, 8'h11, 1'b0, "R6");
        // R12: encodings outside the set.
        send(8'hAB, 8'h12, 8'h34, 8'h56, 1'b1, "R12");
        send(8'hEA, 8'h12, 8'h34, 8'h56, 1'b1, "R12");
        send(8'h9B, 8'h12, 8'h34, 8'h56, 1'b1, "R12");
        // R13: every addressing encoding of the decrement-compare family.
        send(8'hC3, 8'h33, 8'h00, 8'h34, 1'b0, "R13");
        send(8'hCF, 8'h33, 8'h00, 8'h34, 1'b0, "R13");
        send(8'hD7, 8'h33, 8'h00, 8'h34, 1'b0, "R13");
        send(8'hDB, 8'h33, 8'h00, 8'h34, 1'b0, "R13");
        send(8'hDF, 8'h33, 8'h00, 8'h34, 1'b0, "R13");
        idle(3);

        // R2: no strobe while idle, and every request produced a result.
        n_checks++;
        if (out_valid || acc_we || mem_we || flag_en != 4'd0) begin
            n_fail++;
            $display("FAIL R2 idle strobe: actual v=%b expected 0", out_valid);
        end
        n_checks++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing results: actual pending=%0d expected 0", q.size());
        end
        finish_run();
    end
endmodule